// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for a 16-bit asynchronous static RAM with active-low controls. It is built for FPGA prototypes and for synthesizable test harnesses. The strobes are chip select, write strobe, output gate and one enable for each byte. The block samples them on a fast internal clock that runs well above the external cycle rate. From each sample it decides the operating mode and drives what a tri-state data bus would show: an output-enable per byte lane and the read data behind it. Storage is a register array, one bank per byte lane, with a parameterised address width.

Writes are framed as windows. A window opens on the sample in which the last required enable falls, and it closes on the first rising edge of any enable taking part. Only at that close are data and address committed, for the lanes that were enabled. The emulator also reports the decoded mode, so a bench can check mode decoding directly. It flags an address that moves while a write window is open.

Top module: `sram_lane_emu`

## Requirements
- R1: When the sampled chip select is high, or both byte enables are high, the mode output is standby (code 0) and both lane enables are 0.
- R2: With chip select low, write strobe high and output gate high, the mode is output-off (code 1) and both lane enables are 0, whatever the byte enables are (as long as one of them is low).
- R3: With chip select low, write strobe high, output gate low and a byte enable low, the mode is read (code 2). lane_oe[0] follows the lower enable (data bits 7:0) and lane_oe[1] follows the upper enable (bits 15:8). An enabled lane carries the stored byte; a disabled lane reads as zero.
- R4: With chip select and write strobe both low and a byte enable low, the mode is write (code 3), whatever the output gate is. Both lane enables are 0, so a falling write strobe releases a bus that was being driven.
- R5: A write window opens only in the sample where chip select, write strobe and at least one byte enable are low, and where at least one of those four fell since the previous sample. A qualifying state reached without a fresh falling edge opens nothing.
- R6: An open window closes at the first rising edge of chip select, write strobe, or a byte enable that was low in the previous sample. The address and data of the sample before the close are then written into each lane whose enable was low in that sample. Other lanes keep their contents.
- R7: proto_err is 1 in a sample where a window is open and not closing and the address differs from the previous sample's address. Otherwise it is 0.
- R8: Outputs follow inputs one clock after they are sampled. A committed write is readable two clocks after its closing sample. After synchronous reset the mode is standby, lane enables are 0, proto_err is 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data from the bus |
| rdata | output | 16 | Read data; zero on lanes not driven |
| lane_oe | output | 2 | Per-lane drive enable (bit 0 low byte, bit 1 high byte) |
| mode | output | 2 | 0 standby, 1 output-off, 2 read, 3 write |
| proto_err | output | 1 | Address moved inside an open write window |

## Verification
The bench opens a window late by lowering a byte enable last, while strobe and select are already low. A design that opens on a level instead of an edge would instead commit the standby data or miss the window. A window is closed by raising one byte enable. Afterwards new data is applied and the write strobe is released without any fresh falling edge; a design that reopens on level would overwrite the earlier commit. Data changes in the same sample as the closing strobe, which separates committing the last window sample from committing the closing sample. Upper-lane preservation, release of the bus on a falling strobe and a one-sample address move round it out.

// File: rtl/sram_emu_pkg.sv
// Shared types for the byte-lane SRAM emulator.
// Assumes a 16-bit bus made of two 8-bit lanes.
package sram_emu_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OFF     = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } emu_mode_e;

    // Active-low strobes that take part in write framing.
    typedef struct packed {
        logic ce;
        logic we;
        logic ub;
        logic lb;
    } strobe_t;
endpackage

// File: rtl/sram_emu_sampler.sv
// Registers the asynchronous bus inputs once (current sample) and keeps
// the sample before it (previous sample) for edge detection.
// Assumes inputs are already synchronous or metastability-safe upstream.
module sram_emu_sampler
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           in_stb,
    input  logic              in_oe,
    input  logic [AW-1:0]     in_addr,
    input  logic [DATA_W-1:0] in_data,
    output strobe_t           cur_stb,
    output strobe_t           prv_stb,
    output logic              cur_oe,
    output logic [AW-1:0]     cur_addr,
    output logic [AW-1:0]     prv_addr,
    output logic [DATA_W-1:0] cur_data
);
    localparam strobe_t IDLE = '{ce: 1'b1, we: 1'b1, ub: 1'b1, lb: 1'b1};

    // Two-deep history of strobes and address; data needs one sample only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_stb  <= IDLE;
            prv_stb  <= IDLE;
            cur_oe   <= 1'b1;
            cur_addr <= '0;
            prv_addr <= '0;
            cur_data <= '0;
        end else begin
            cur_stb  <= in_stb;
            prv_stb  <= cur_stb;
            cur_oe   <= in_oe;
            cur_addr <= in_addr;
            prv_addr <= cur_addr;
            cur_data <= in_data;
        end
    end
endmodule

// File: rtl/sram_emu_mode_dec.sv
// Decodes the operating mode from one strobe sample and forms the
// per-lane drive enables. Priority: standby, write, output-off, read.
module sram_emu_mode_dec
    import sram_emu_pkg::*;
(
    input  strobe_t          stb,
    input  logic             oe,
    output emu_mode_e        mode,
    output logic [LANES-1:0] lane_oe
);
    logic no_lane;

    // Mode priority decode.
    always_comb begin
        no_lane = stb.ub & stb.lb;
        if (stb.ce || no_lane)  mode = MODE_STANDBY;
        else if (!stb.we)       mode = MODE_WRITE;
        else if (oe)            mode = MODE_OFF;
        else                    mode = MODE_READ;
    end

    // Lanes drive only in read mode, each under its own enable.
    always_comb begin
        lane_oe = '0;
        if (mode == MODE_READ) lane_oe = {~stb.ub, ~stb.lb};
    end
endmodule

// File: rtl/sram_emu_wr_window.sv
// Tracks the write window: opens on the last falling edge that makes the
// write condition true, closes on the first rising edge of a participating
// strobe, and hands the sample before the close to storage as a commit.
// Also flags an address that moves while the window is open.
module sram_emu_wr_window
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           cur_stb,
    input  strobe_t           prv_stb,
    input  logic [AW-1:0]     cur_addr,
    input  logic [AW-1:0]     prv_addr,
    input  logic [DATA_W-1:0] cur_data,
    output logic              wr_en,
    output logic [LANES-1:0]  wr_lanes,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              proto_err
);
    logic              win_q;
    logic              qual, any_fell, any_rose, open_now, close_now, keep;
    logic [LANES-1:0]  held_lanes;
    logic [AW-1:0]     held_addr;
    logic [DATA_W-1:0] held_data;

    // Edge and qualification terms from the two samples.
    always_comb begin
        qual      = ~cur_stb.ce & ~cur_stb.we & (~cur_stb.ub | ~cur_stb.lb);
        any_fell  = (prv_stb.ce & ~cur_stb.ce) | (prv_stb.we & ~cur_stb.we) |
                    (prv_stb.ub & ~cur_stb.ub) | (prv_stb.lb & ~cur_stb.lb);
        any_rose  = (~prv_stb.ce & cur_stb.ce) | (~prv_stb.we & cur_stb.we) |
                    (~prv_stb.ub & cur_stb.ub) | (~prv_stb.lb & cur_stb.lb);
        open_now  = ~win_q & qual & any_fell;
        close_now = win_q & (any_rose | ~qual);
        keep      = open_now | (win_q & ~close_now);
    end

    // Window state and the held sample that a close will commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= 1'b0;
            held_lanes <= '0;
            held_addr  <= '0;
            held_data  <= '0;
        end else begin
            win_q <= keep;
            if (keep) begin
                held_lanes <= {~cur_stb.ub, ~cur_stb.lb};
                held_addr  <= cur_addr;
                held_data  <= cur_data;
            end
        end
    end

    // Commit request toward storage.
    always_comb begin
        wr_en    = close_now;
        wr_lanes = held_lanes;
        wr_addr  = held_addr;
        wr_data  = held_data;
    end

    // Address instability inside a live window.
    always_comb proto_err = win_q & ~close_now & (cur_addr != prv_addr);
endmodule

// File: rtl/sram_emu_lane_mem.sv
// Register-array storage, one bank per byte lane, with a lane-masked
// write port and a read port gated by the lane drive enables.
// Storage is not reset; contents are undefined until written.
module sram_emu_lane_mem
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic [LANES-1:0]  rd_lane_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        // Commit this lane's byte when its enable was part of the window.
        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Present the stored byte only when the lane is driven.
        always_comb rd_data[g*LANE_W +: LANE_W] =
            rd_lane_oe[g] ? bank[rd_addr] : '0;
    end
endmodule

// File: rtl/sram_lane_emu.sv
// Top of the byte-lane SRAM emulator: sampler, mode decode, write window
// tracking and lane storage. Assumes clk oversamples the bus strobes.
module sram_lane_emu
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  lane_oe,
    output logic [1:0]        mode,
    output logic              proto_err
);
    strobe_t           in_stb, cur_stb, prv_stb;
    logic              cur_oe;
    logic [AW-1:0]     cur_addr, prv_addr, wr_addr;
    logic [DATA_W-1:0] cur_data, wr_data;
    logic              wr_en;
    logic [LANES-1:0]  wr_lanes;
    emu_mode_e         mode_w;

    // Pack the raw strobes.
    always_comb in_stb = '{ce: ce_n, we: we_n, ub: ub_n, lb: lb_n};

    sram_emu_sampler #(.AW(AW)) u_smp (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_oe(oe_n),
        .in_addr(addr), .in_data(wdata), .cur_stb(cur_stb), .prv_stb(prv_stb),
        .cur_oe(cur_oe), .cur_addr(cur_addr), .prv_addr(prv_addr),
        .cur_data(cur_data)
    );

    sram_emu_mode_dec u_dec (
        .stb(cur_stb), .oe(cur_oe), .mode(mode_w), .lane_oe(lane_oe)
    );

    sram_emu_wr_window #(.AW(AW)) u_win (
        .clk(clk), .rst_n(rst_n), .cur_stb(cur_stb), .prv_stb(prv_stb),
        .cur_addr(cur_addr), .prv_addr(prv_addr), .cur_data(cur_data),
        .wr_en(wr_en), .wr_lanes(wr_lanes), .wr_addr(wr_addr),
        .wr_data(wr_data), .proto_err(proto_err)
    );

    sram_emu_lane_mem #(.AW(AW)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_lanes(wr_lanes), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(cur_addr), .rd_lane_oe(lane_oe),
        .rd_data(rdata)
    );

    // Export the decoded mode as its code.
    always_comb mode = mode_w;
endmodule

// File: rtl/sram_lane_emu_chk.sv
// Port-level properties of the emulator, bound to the top module.
// Outputs reflect the inputs registered at the previous clock edge.
module sram_lane_emu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       ub_n,
    input logic       lb_n,
    input logic [1:0] lane_oe,
    input logic [1:0] mode,
    input logic       proto_err
);
    a_r1_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(ce_n) || ($past(ub_n) && $past(lb_n)))
        |-> (mode == 2'd0) && (lane_oe == 2'b00));

    a_r2_output_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!ce_n && we_n && oe_n && !(ub_n && lb_n))
        |-> (mode == 2'd1) && (lane_oe == 2'b00));

    a_r3_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (mode == 2'd2)
        |-> lane_oe == {!$past(ub_n), !$past(lb_n)});

    a_r4_write_release: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!ce_n && !we_n && !(ub_n && lb_n))
        |-> (mode == 2'd3) && (lane_oe == 2'b00));

    a_r7_err_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> mode == 2'd3);
endmodule

bind sram_lane_emu sram_lane_emu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .lane_oe(lane_oe), .mode(mode),
    .proto_err(proto_err)
);

// File: tb/sim_sram_lane_emu.sv
// Scoreboard bench: driver tasks queue expected outputs, a monitor
// compares them at the falling clock edge.
module sim_sram_lane_emu;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    lane_oe;
    logic [1:0]    mode;
    logic          proto_err;

    always #4 clk = ~clk;

    sram_lane_emu #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .lane_oe(lane_oe), .mode(mode), .proto_err(proto_err)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [1:0]  loe;
        logic [15:0] rd;
        logic        pe;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // Apply one bus sample at the falling edge.
    task automatic drive(input logic c, input logic w, input logic o,
                         input logic u, input logic l,
                         input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; wdata = d;
    endtask

    // Queue an expectation after the given number of rising edges.
    task automatic expect_out(input int settle, input logic [1:0] m,
                              input logic [1:0] loe, input logic [15:0] rd,
                              input logic pe, input string tag);
        exp_t e;
        repeat (settle) @(posedge clk);
        e = '{m: m, loe: loe, rd: rd, pe: pe};
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Full word write framed by the write strobe.
    task automatic write_word(input logic [AW-1:0] a, input logic [15:0] d);
        drive(0, 1, 1, 0, 0, a, d);
        drive(0, 0, 1, 0, 0, a, d);
        drive(0, 0, 1, 0, 0, a, d);
        drive(0, 1, 1, 0, 0, a, d);
        drive(1, 1, 1, 1, 1, a, d);
    endtask

    // Monitor: compare every queued expectation with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (q_exp.size() > 0) begin
                exp_t  e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_cmp++;
                if (mode !== e.m || lane_oe !== e.loe || rdata !== e.rd ||
                    proto_err !== e.pe) begin
                    n_bad++;
                    $display("FAIL %s: got mode=%0d oe=%b rd=%h err=%b, want mode=%0d oe=%b rd=%h err=%b",
                             t, mode, lane_oe, rdata, proto_err, e.m, e.loe, e.rd, e.pe);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_out(1, 0, 2'b00, 16'h0000, 0, "R8 reset state");

        // R1: select high, then both byte enables high.
        drive(1, 1, 0, 0, 0, 8'd5, 16'h0);
        expect_out(1, 0, 2'b00, 16'h0000, 0, "R1 select high");
        drive(0, 1, 0, 1, 1, 8'd5, 16'h0);
        expect_out(1, 0, 2'b00, 16'h0000, 0, "R1 both enables high");

        // R4: write mode with output gate low releases the lanes.
        drive(0, 1, 0, 0, 0, 8'd5, 16'h1234);
        drive(0, 0, 0, 0, 0, 8'd5, 16'h1234);
        expect_out(1, 3, 2'b00, 16'h0000, 0, "R4 write with gate low");
        drive(0, 1, 0, 0, 0, 8'd5, 16'h1234);
        drive(1, 1, 1, 1, 1, 8'd5, 16'h0);

        // R3 / R8: word and byte reads of the committed word.
        drive(0, 1, 0, 0, 0, 8'd5, 16'h0);
        expect_out(1, 2, 2'b11, 16'h1234, 0, "R3 word read");
        drive(0, 1, 0, 1, 0, 8'd5, 16'h0);
        expect_out(1, 2, 2'b01, 16'h0034, 0, "R3 lower lane read");
        drive(0, 1, 0, 0, 1, 8'd5, 16'h0);
        expect_out(1, 2, 2'b10, 16'h1200, 0, "R3 upper lane read");

        // R2: output gate high, byte enables varied.
        drive(0, 1, 1, 0, 0, 8'd5, 16'h0);
        expect_out(1, 1, 2'b00, 16'h0000, 0, "R2 gate high word");
        drive(0, 1, 1, 1, 0, 8'd5, 16'h0);
        expect_out(1, 1, 2'b00, 16'h0000, 0, "R2 gate high lower only");

        // R5 / R6: window opened late by the lower enable.
        write_word(8'd6, 16'h5566);
        drive(0, 0, 1, 1, 1, 8'd6, 16'h00AA);
        expect_out(1, 0, 2'b00, 16'h0000, 0, "R5 no window while enables high");
        drive(0, 0, 1, 1, 0, 8'd6, 16'h00AA);
        expect_out(1, 3, 2'b00, 16'h0000, 0, "R5 window opens on lower fall");
        drive(0, 0, 1, 1, 1, 8'd6, 16'h00AA);
        drive(1, 1, 1, 1, 1, 8'd6, 16'h0);
        drive(0, 1, 0, 0, 0, 8'd6, 16'h0);
        expect_out(1, 2, 2'b11, 16'h55AA, 0, "R6 upper lane kept");

        // R5 / R6: close on upper enable rise, no reopen without a fall.
        write_word(8'd7, 16'h0000);
        drive(0, 1, 1, 0, 0, 8'd7, 16'h7777);
        drive(0, 0, 1, 0, 0, 8'd7, 16'h7777);
        drive(0, 0, 1, 1, 0, 8'd7, 16'h7777);
        drive(0, 0, 1, 1, 0, 8'd7, 16'h9999);
        drive(0, 1, 1, 1, 0, 8'd7, 16'h9999);
        drive(1, 1, 1, 1, 1, 8'd7, 16'h0);
        drive(0, 1, 0, 0, 0, 8'd7, 16'h0);
        expect_out(1, 2, 2'b11, 16'h7777, 0, "R5 R6 close on enable rise, no reopen");

        // R6: data changing with the closing strobe is not committed.
        drive(0, 1, 1, 0, 0, 8'd8, 16'h4242);
        drive(0, 0, 1, 0, 0, 8'd8, 16'h4242);
        drive(0, 1, 1, 0, 0, 8'd8, 16'hDEAD);
        drive(1, 1, 1, 1, 1, 8'd8, 16'h0);
        drive(0, 1, 0, 0, 0, 8'd8, 16'h0);
        expect_out(1, 2, 2'b11, 16'h4242, 0, "R6 prior sample committed");

        // R7: address move inside a window; close on select rise.
        drive(0, 1, 1, 0, 0, 8'd9, 16'h1111);
        drive(0, 0, 1, 0, 0, 8'd9, 16'h1111);
        expect_out(1, 3, 2'b00, 16'h0000, 0, "R7 stable address no error");
        drive(0, 0, 1, 0, 0, 8'd10, 16'h2222);
        expect_out(1, 3, 2'b00, 16'h0000, 1, "R7 address moved");
        drive(1, 0, 1, 0, 0, 8'd10, 16'h2222);
        drive(1, 1, 1, 1, 1, 8'd10, 16'h0);
        drive(0, 1, 0, 0, 0, 8'd10, 16'h0);
        expect_out(1, 2, 2'b11, 16'h2222, 0, "R6 R7 commit at last address");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule